// File: doc/BRIEF.md
# Conversion Result Code Formatter

This block takes the signed, extended-range result of a sigma-delta converter's decimation filter and turns it into a 16-bit channel data word together with two status bits. The negative flag is set for any result below zero input. The out-of-range flag is set for any result outside the nominal code span. The input is an 18-bit two's-complement number. Nominal full scale corresponds to ±2^16 input codes, and the input may reach about 1.16 times full scale in either direction.

A mode input selects the word encoding. Bipolar mode gives offset binary over the range from -full-scale to +full-scale. Unipolar mode gives straight binary over the range from zero to +full-scale. A saturation control chooses what happens to results outside the nominal span. When it is off, the word keeps the low 16 bits of the extended code, so it wraps, and the two status bits are needed to decode it. When it is on, the word is pinned to all ones or all zeros. Every output is registered and updates on the clock after a valid strobe, and a one-cycle ready pulse marks that update.

Top module: `code_formatter`

## Requirements
- R1: While rst_n is low at a clock edge, out_word, out_sign, out_ovr and out_rdy are all cleared to 0.
- R2: Bipolar mode (in_uni=0) with saturation off: the word is the low 16 bits of floor(x/2)+0x8000, where x is in_result read as two's complement. Zero gives 0x8000, x=-1 gives 0x7FFF, x=65535 gives 0xFFFF and x=-65536 gives 0x0000.
- R3: Unipolar mode (in_uni=1) with saturation off: the word is the low 16 bits of x. Zero gives 0x0000 and x=65535 gives 0xFFFF.
- R4: out_sign is 1 exactly when x is negative, in both modes.
- R5: In bipolar mode out_ovr is 1 exactly when x>65535 or x<-65536. For example, x=65536 gives 0x0000 with out_ovr=1, and x=-65537 gives 0xFFFF with out_sign=1 and out_ovr=1.
- R6: In unipolar mode out_ovr is 1 exactly when x<0 or x>65535, so every negative result is flagged.
- R7: With in_clamp=0, an out-of-range result still shows the low 16 bits of the extended code.
- R8: With in_clamp=1, an out-of-range result above the span gives 0xFFFF and one below it gives 0x0000. out_sign and out_ovr are unchanged by in_clamp, and in-range results are not affected.
- R9: The outputs take the new values on the clock edge where in_vld is high, and out_rdy is high for exactly the cycle after each in_vld.
- R10: When in_vld is low, out_word, out_sign and out_ovr hold their values.
- R11: The full extended span causes no internal overflow. Bipolar x=76022 gives 0x147B, bipolar x=-76022 gives 0xEB85 and unipolar x=76021 gives 0x28F5, each with out_ovr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | A new result is present on in_result |
| in_result | input | 18 | Signed conversion result, two's complement |
| in_uni | input | 1 | 1 selects unipolar, 0 selects bipolar |
| in_clamp | input | 1 | 1 saturates out-of-range words |
| out_word | output | 16 | Registered channel data word |
| out_sign | output | 1 | Result was negative |
| out_ovr | output | 1 | Result was outside the nominal span |
| out_rdy | output | 1 | One-cycle pulse after each accepted result |

## Verification
Directed values sit on each side of every range edge: -1 and 0, and ±full scale with one code past it, in both modes and with saturation on and off. These values separate an off-by-one in the limits from an error in the offset or in the halving. The extreme points of the extended span show whether the arithmetic is wide enough, because a narrow adder changes the wrapped word. Random results across the whole span, with random mode, saturation and gaps in the strobe, exercise the hold behaviour and the strobe timing, and a bench model checks every word.

// File: rtl/code_fmt_pkg.sv
// Shared types for the code formatter.
// Assumes: nothing beyond the standard language.
package code_fmt_pkg;
    typedef enum logic {
        MODE_BIPOLAR  = 1'b0,
        MODE_UNIPOLAR = 1'b1
    } code_mode_e;

    typedef struct packed {
        logic above;   // result above the nominal span
        logic below;   // result below the nominal span
        logic neg;     // result negative
    } range_flags_t;
endpackage

// File: rtl/code_range_map.sv
// Maps a signed result onto the extended code axis of the selected mode and
// classifies it against the nominal span.
// Assumes: IN_W > OUT_W + 1, so that the extended code plus one guard bit fits.
module code_range_map
    import code_fmt_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  res,
    input  code_mode_e       mode,
    output logic [OUT_W-1:0] low_code,
    output range_flags_t     flags
);
    localparam int EXT_W = IN_W + 1;
    localparam int MID_I = 2 ** (OUT_W - 1);
    localparam int TOP_I = 2 ** OUT_W - 1;
    localparam logic signed [EXT_W-1:0] MID = EXT_W'(MID_I);
    localparam logic signed [EXT_W-1:0] TOP = EXT_W'(TOP_I);

    logic signed [EXT_W-1:0] x_ext;
    logic signed [EXT_W-1:0] half_ext;
    logic signed [EXT_W-1:0] ext;

    // Sign-extend, then halve for the bipolar code axis.
    always_comb begin
        x_ext    = {res[IN_W-1], res};
        half_ext = x_ext >>> 1;
        ext      = (mode == MODE_UNIPOLAR) ? x_ext : (half_ext + MID);
    end

    // Compare with the nominal span and keep the low code bits.
    always_comb begin
        flags.above = (ext > TOP);
        flags.below = ext[EXT_W-1];
        flags.neg   = res[IN_W-1];
        low_code    = ext[OUT_W-1:0];
    end
endmodule

// File: rtl/code_saturate.sv
// Chooses between the wrapped code and a saturated rail value.
// Assumes: above and below are never both set.
module code_saturate
    import code_fmt_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic [OUT_W-1:0] low_code,
    input  range_flags_t     flags,
    input  logic             sat_en,
    output logic [OUT_W-1:0] word,
    output logic             ovr
);
    // Pin the word to a rail when saturation is enabled and out of range.
    always_comb begin
        ovr = flags.above | flags.below;
        if (sat_en && flags.above)
            word = '1;
        else if (sat_en && flags.below)
            word = '0;
        else
            word = low_code;
    end
endmodule

// File: rtl/code_formatter.sv
// Top of the formatter: maps, optionally saturates and registers a result.
// Assumes: in_result is valid only while in_vld is high.
module code_formatter
    import code_fmt_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_result,
    input  logic             in_uni,
    input  logic             in_clamp,
    output logic [OUT_W-1:0] out_word,
    output logic             out_sign,
    output logic             out_ovr,
    output logic             out_rdy
);
    logic [OUT_W-1:0] low_code;
    logic [OUT_W-1:0] next_word;
    logic             next_ovr;
    range_flags_t     flags;
    code_mode_e       mode;

    assign mode = code_mode_e'(in_uni);

    code_range_map #(.IN_W(IN_W), .OUT_W(OUT_W)) u_map (
        .res      (in_result),
        .mode     (mode),
        .low_code (low_code),
        .flags    (flags)
    );

    code_saturate #(.OUT_W(OUT_W)) u_sat (
        .low_code (low_code),
        .flags    (flags),
        .sat_en   (in_clamp),
        .word     (next_word),
        .ovr      (next_ovr)
    );

    // Capture the formatted result on each valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_sign <= 1'b0;
            out_ovr  <= 1'b0;
        end else if (in_vld) begin
            out_word <= next_word;
            out_sign <= flags.neg;
            out_ovr  <= next_ovr;
        end
    end

    // Ready pulse one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) out_rdy <= 1'b0;
        else        out_rdy <= in_vld;
    end
endmodule

// File: rtl/code_formatter_chk.sv
// Temporal checks on the formatter ports.
module code_formatter_chk #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [IN_W-1:0]  in_result,
    input logic             in_uni,
    input logic             in_clamp,
    input logic [OUT_W-1:0] out_word,
    input logic             out_sign,
    input logic             out_ovr,
    input logic             out_rdy
);
    // R9
    rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_rdy);
    // R9
    rdy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_rdy);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_word) && $stable(out_sign) && $stable(out_ovr)));
    // R4
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_sign == $past(in_result[IN_W-1])));
    // R6
    uni_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_uni && in_result[IN_W-1]) |=> (out_ovr && out_sign));
    // R8
    clamp_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_clamp) |=> (!out_ovr || out_word == '0 || out_word == '1));
    // R2
    bip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_uni && in_result == '0) |=>
        (out_word == OUT_W'(2 ** (OUT_W - 1)) && !out_ovr));
endmodule

bind code_formatter code_formatter_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/sim_code_formatter.sv
module sim_code_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [17:0] in_result = '0;
    logic        in_uni = 1'b0;
    logic        in_clamp = 1'b0;
    logic [15:0] out_word;
    logic        out_sign, out_ovr, out_rdy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    code_formatter u0 (.*);

    // Reference word, sign and ovr from the requirements (R2..R8, R11).
    function automatic void model(input int x, input bit uni, input bit clp,
                                  output logic [15:0] w, output bit s, output bit o);
        int e;
        e = uni ? x : ((x >>> 1) + 32768);
        o = (e < 0) || (e > 65535);
        s = (x < 0);
        if (clp && e > 65535)  w = 16'hFFFF;
        else if (clp && e < 0) w = 16'h0000;
        else                   w = e[15:0];
    endfunction

    task automatic check(input string tag, input logic [15:0] aw, input logic [15:0] ew,
                         input bit as, input bit es, input bit ao, input bit eo);
        n_chk++;
        if (aw !== ew || as !== es || ao !== eo) begin
            n_bad++;
            $display("FAIL %s: word=%h sign=%b ovr=%b expected word=%h sign=%b ovr=%b",
                     tag, aw, as, ao, ew, es, eo);
        end
    endtask

    // Apply one result and check it in the following cycle (R9).
    task automatic apply(input string tag, input int x, input bit uni, input bit clp);
        logic [15:0] ew; bit es, eo;
        model(x, uni, clp, ew, es, eo);
        in_result = 18'(x); in_uni = uni; in_clamp = clp; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check(tag, out_word, ew, out_sign, es, out_ovr, eo);
        n_chk++;
        if (out_rdy !== 1'b1) begin
            n_bad++; $display("FAIL R9: rdy=%b expected 1", out_rdy);
        end
    endtask

    initial begin
        logic [15:0] hw; bit hs, ho;
        void'($urandom(1234));
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1", out_word, 16'h0, out_sign, 1'b0, out_ovr, 1'b0);
        n_chk++;
        if (out_rdy !== 1'b0) begin n_bad++; $display("FAIL R1: rdy=%b expected 0", out_rdy); end
        rst_n = 1'b1;
        @(negedge clk);
        // R2 bipolar edges
        apply("R2 zero", 0, 0, 0);
        apply("R2 minus1", -1, 0, 0);
        apply("R2 +fs", 65535, 0, 0);
        apply("R2 -fs", -65536, 0, 0);
        // R3 unipolar edges
        apply("R3 zero", 0, 1, 0);
        apply("R3 +fs", 65535, 1, 0);
        // R5 / R7 bipolar beyond range, wrapped
        apply("R5 R7 above", 65536, 0, 0);
        apply("R5 R7 below", -65537, 0, 0);
        // R6 unipolar negative and above
        apply("R6 neg", -1, 1, 0);
        apply("R6 above", 65536, 1, 0);
        // R8 saturation
        apply("R8 bip above", 65536, 0, 1);
        apply("R8 bip below", -65537, 0, 1);
        apply("R8 uni neg", -1, 1, 1);
        apply("R8 uni above", 70000, 1, 1);
        apply("R8 in range", 1234, 0, 1);
        // R11 extremes of the extended span
        apply("R11 bip top", 76022, 0, 0);
        apply("R11 bip bottom", -76022, 0, 0);
        apply("R11 uni top", 76021, 1, 0);
        // R10 hold while idle, with inputs changing
        model(76021, 1, 0, hw, hs, ho);
        in_result = 18'h20000; in_uni = 1'b0; in_clamp = 1'b1;
        @(negedge clk);
        check("R10 hold", out_word, hw, out_sign, hs, out_ovr, ho);
        n_chk++;
        if (out_rdy !== 1'b0) begin n_bad++; $display("FAIL R9: rdy=%b expected 0", out_rdy); end
        // R4 R2 R3 random mix with idle gaps
        for (int i = 0; i < 3000; i++) begin
            int x;
            x = int'($urandom_range(152044)) - 76022;
            apply("R4 random", x, 1'($urandom), 1'($urandom));
            if ($urandom_range(3) == 0) @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule